// File: doc/BRIEF.md
# 12-Hour Digital Clock Counter Chain

This block keeps time of day on a 12-hour dial from a 50 Hz square-wave reference. The reference is synchronised into the system clock domain and its rising edges are found there. A prescaler counts those edges and gives a one-cycle seconds strobe once every fifty edges. The strobe then runs through a chain of BCD counters for seconds, minutes and hours. Each counter passes a one-cycle carry to the next one only on the cycle it wraps.

Seconds and minutes each use a pair of digits: a decade ones digit and a tens digit that runs 0 to 5. Hours use a decade ones digit and one tens bit. The hour runs 12, 1, 2 … 11, 12 and then goes back to 1, so it never shows zero. Everything runs on one system clock with clock enables. The digit outputs come straight from flip-flops, so a display decoder or a strobed latch downstream never sees a glitch.

Top module: `clock12_chain`

## Requirements
- R1: A synchronous reset sets the time to 12:00:00 (hr_tens=1, hr_ones=2, every other digit 0).
- R2: The seconds advance by one for every TICK_DIV (default 50) rising edges seen on tick_50hz. A tick held steady high or low for any number of cycles does not advance the time.
- R3: Each seconds digit is BCD. sec_ones counts 0 to 9 and sec_tens counts 0 to 5. The tens digit changes only on the advance where the ones digit wraps from 9 to 0.
- R4: Seconds wrap from 59 to 00. The minutes change only on an advance where the seconds are at 59.
- R5: Minutes follow the same digit rules as seconds and wrap from 59 to 00. The hours change only on an advance where minutes and seconds are both at 59.
- R6: The hour tens bit sets on the advance where the hour ones digit wraps from 9 to 0 (09:59:59 becomes 10:00:00).
- R7: The advance after 12:59:59 gives 01:00:00: the hour ones digit is loaded with 1 and the tens bit is cleared. The hour is always between 1 and 12.
- R8: 11:59:59 advances to 12:00:00.
- R9: All digits that change on an advance change in the same clock cycle. Every output is driven from a register: ones digits are 4 bits wide, tens digits 3 bits, and the hour tens digit 1 bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_50hz | input | 1 | 50 Hz square-wave reference, asynchronous |
| hr_tens | output | 1 | Hour tens digit (0 or 1) |
| hr_ones | output | 4 | Hour ones digit, BCD |
| min_tens | output | 3 | Minute tens digit, 0 to 5 |
| min_ones | output | 4 | Minute ones digit, BCD |
| sec_tens | output | 3 | Second tens digit, 0 to 5 |
| sec_ones | output | 4 | Second ones digit, BCD |

## Verification
The rarest event at the ports is the hour rollover, and the reload from 12:59:59 to 01:00:00 in particular. At the default prescale a full dial is millions of clock cycles away. The bench therefore runs a second instance with the prescale set to 1 and toggles its tick every cycle, so one second costs two cycles. It drives that instance through a full 12-hour turn and past it. It pauses just before and just after each hour boundary of interest and compares all digits with times computed from the number of edges sent. The default instance covers the divide-by-50 count, held tick levels, and random bursts and gaps.

// File: rtl/clock12_pkg.sv
package clock12_pkg;
  localparam int ONES_W   = 4;
  localparam int TENS_W   = 3;
  localparam int ONES_TOP = 9;
  localparam int MIN_TENS_TOP = 5;
  localparam int HOUR_TENS_RELOAD_AT = 2;
  typedef logic [ONES_W-1:0] ones_t;
  typedef logic [TENS_W-1:0] tens_t;
endpackage

// File: rtl/clock12_tick_edge.sv
module clock12_tick_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_in,
  output logic rise_o
);
  logic [SYNC_STAGES:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_q <= '0;
      rise_o <= 1'b0;
    end else begin
      pipe_q <= {pipe_q[SYNC_STAGES-1:0], tick_in};
      rise_o <= pipe_q[SYNC_STAGES-1] & ~pipe_q[SYNC_STAGES];
    end
  end
endmodule

// File: rtl/clock12_prescale.sv
module clock12_prescale #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic step_i,
  output logic pulse_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      if (step_i) begin
        if (cnt_q == LAST) begin
          cnt_q   <= '0;
          pulse_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/clock12_bcd_pair.sv
module clock12_bcd_pair
  import clock12_pkg::*;
#(
  parameter int TENS_LAST = MIN_TENS_TOP
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  adv_i,
  output ones_t ones_o,
  output tens_t tens_o,
  output logic  carry_o
);
  localparam ones_t ONES_LAST = ones_t'(ONES_TOP);
  localparam tens_t TENS_END  = tens_t'(TENS_LAST);

  logic ones_wrap;
  assign ones_wrap = (ones_o == ONES_LAST);
  assign carry_o   = adv_i && ones_wrap && (tens_o == TENS_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      ones_o <= '0;
      tens_o <= '0;
    end else if (adv_i) begin
      if (ones_wrap) begin
        ones_o <= '0;
        tens_o <= (tens_o == TENS_END) ? '0 : tens_o + 1'b1;
      end else begin
        ones_o <= ones_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clock12_hour_stage.sv
module clock12_hour_stage
  import clock12_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  adv_i,
  output ones_t ones_o,
  output logic  tens_o
);
  localparam ones_t ONES_LAST = ones_t'(ONES_TOP);
  localparam ones_t NOON_ONES = ones_t'(HOUR_TENS_RELOAD_AT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ones_o <= NOON_ONES;
      tens_o <= 1'b1;
    end else if (adv_i) begin
      if (tens_o && ones_o == NOON_ONES) begin
        ones_o <= ones_t'(1);
        tens_o <= 1'b0;
      end else if (ones_o == ONES_LAST) begin
        ones_o <= '0;
        tens_o <= 1'b1;
      end else begin
        ones_o <= ones_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clock12_chain.sv
module clock12_chain
  import clock12_pkg::*;
#(
  parameter int TICK_DIV    = 50,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_50hz,
  output logic       hr_tens,
  output logic [3:0] hr_ones,
  output logic [2:0] min_tens,
  output logic [3:0] min_ones,
  output logic [2:0] sec_tens,
  output logic [3:0] sec_ones
);
  localparam int NUM_PAIRS = 2;

  logic tick_rise;
  logic sec_en;
  logic [NUM_PAIRS:0] adv;
  ones_t pair_ones [NUM_PAIRS];
  tens_t pair_tens [NUM_PAIRS];

  clock12_tick_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
    .clk(clk), .rst(rst), .tick_in(tick_50hz), .rise_o(tick_rise)
  );

  clock12_prescale #(.DIV(TICK_DIV)) pre_i (
    .clk(clk), .rst(rst), .step_i(tick_rise), .pulse_o(sec_en)
  );

  assign adv[0] = sec_en;

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    clock12_bcd_pair #(.TENS_LAST(MIN_TENS_TOP)) pair_i (
      .clk(clk), .rst(rst), .adv_i(adv[g]),
      .ones_o(pair_ones[g]), .tens_o(pair_tens[g]), .carry_o(adv[g+1])
    );
  end

  clock12_hour_stage hour_i (
    .clk(clk), .rst(rst), .adv_i(adv[NUM_PAIRS]),
    .ones_o(hr_ones), .tens_o(hr_tens)
  );

  assign sec_ones = pair_ones[0];
  assign sec_tens = pair_tens[0];
  assign min_ones = pair_ones[1];
  assign min_tens = pair_tens[1];
endmodule

// File: rtl/clock12_chain_chk.sv
module clock12_chain_chk (
  input logic       clk,
  input logic       rst,
  input logic       sec_en,
  input logic       hr_tens,
  input logic [3:0] hr_ones,
  input logic [2:0] min_tens,
  input logic [3:0] min_ones,
  input logic [2:0] sec_tens,
  input logic [3:0] sec_ones
);
  logic sec59, min59;
  assign sec59 = (sec_tens == 3'd5) && (sec_ones == 4'd9);
  assign min59 = (min_tens == 3'd5) && (min_ones == 4'd9);

  p_sec_only_on_en_r2: assert property (@(posedge clk) disable iff (rst)
    !sec_en |=> $stable({sec_tens, sec_ones}));

  p_sec_range_r3: assert property (@(posedge clk) disable iff (rst)
    (sec_ones <= 4'd9) && (sec_tens <= 3'd5));

  p_sec_tens_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (sec_ones != 4'd9) |=> $stable(sec_tens));

  p_min_on_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    !(sec_en && sec59) |=> $stable({min_tens, min_ones}));

  p_min_range_r5: assert property (@(posedge clk) disable iff (rst)
    (min_ones <= 4'd9) && (min_tens <= 3'd5));

  p_hour_on_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    !(sec_en && sec59 && min59) |=> $stable({hr_tens, hr_ones}));

  p_hour_range_r7: assert property (@(posedge clk) disable iff (rst)
    hr_tens ? (hr_ones <= 4'd2) : ((hr_ones != 4'd0) && (hr_ones <= 4'd9)));

  p_hour_reload_r7: assert property (@(posedge clk) disable iff (rst)
    (sec_en && sec59 && min59 && hr_tens && hr_ones == 4'd2)
      |=> (!hr_tens && hr_ones == 4'd1));

  p_hour_tens_set_r6: assert property (@(posedge clk) disable iff (rst)
    (sec_en && sec59 && min59 && !hr_tens && hr_ones == 4'd9)
      |=> (hr_tens && hr_ones == 4'd0));
endmodule

bind clock12_chain clock12_chain_chk chk_i (
  .clk(clk), .rst(rst), .sec_en(sec_en),
  .hr_tens(hr_tens), .hr_ones(hr_ones),
  .min_tens(min_tens), .min_ones(min_ones),
  .sec_tens(sec_tens), .sec_ones(sec_ones)
);

// File: tb/clock12_chain_tb.sv
module clock12_chain_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_a = 1'b0;
  logic tick_b = 1'b0;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  int unsigned edges_a = 0;
  int unsigned edges_b = 0;

  logic       ht_a, ht_b;
  logic [3:0] ho_a, ho_b, mo_a, mo_b, so_a, so_b;
  logic [2:0] mt_a, mt_b, st_a, st_b;

  always #2 clk = ~clk;

  clock12_chain dut_i (
    .clk(clk), .rst(rst), .tick_50hz(tick_a),
    .hr_tens(ht_a), .hr_ones(ho_a), .min_tens(mt_a), .min_ones(mo_a),
    .sec_tens(st_a), .sec_ones(so_a)
  );

  clock12_chain #(.TICK_DIV(1)) dut_fast_i (
    .clk(clk), .rst(rst), .tick_50hz(tick_b),
    .hr_tens(ht_b), .hr_ones(ho_b), .min_tens(mt_b), .min_ones(mo_b),
    .sec_tens(st_b), .sec_ones(so_b)
  );

  function automatic logic [18:0] exp_time(int unsigned secs);
    int s, h, m, sc;
    s  = int'(secs % 43200);
    h  = s / 3600;
    if (h == 0) h = 12;
    m  = (s / 60) % 60;
    sc = s % 60;
    return {1'(h / 10), 4'(h % 10), 3'(m / 10), 4'(m % 10), 3'(sc / 10), 4'(sc % 10)};
  endfunction

  task automatic check(input bit fast, input int unsigned secs, input string req);
    logic [18:0] got, exp;
    got = fast ? {ht_b, ho_b, mt_b, mo_b, st_b, so_b}
               : {ht_a, ho_a, mt_a, mo_a, st_a, so_a};
    exp = exp_time(secs);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (seconds=%0d)", req, got, exp, secs);
    end
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  task automatic edges_on_a(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_a = 1'b1;
      @(negedge clk) tick_a = 1'b0;
    end
    edges_a += n;
  endtask

  task automatic fast_to(input int unsigned target);
    while (edges_b < target) begin
      @(negedge clk) tick_b = 1'b1;
      @(negedge clk) tick_b = 1'b0;
      edges_b++;
    end
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle();
    check(1'b0, 0, "R1 reset to 12:00:00");
    check(1'b1, 0, "R1 reset fast instance");

    // R2: 49 edges leave the time, the 50th advances it
    edges_on_a(49);
    settle();
    check(1'b0, edges_a / 50, "R2 49 edges no advance");
    edges_on_a(1);
    settle();
    check(1'b0, edges_a / 50, "R2 50th edge advances");

    // R2: level held high for a long time is not an edge
    @(negedge clk) tick_a = 1'b1;
    edges_a += 1;
    repeat (300) @(negedge clk);
    tick_a = 1'b0;
    settle();
    check(1'b0, edges_a / 50, "R2 held high counts once");

    // random bursts with random idle gaps
    for (int b = 0; b < 12; b++) begin
      edges_on_a(int'($urandom_range(1, 250)));
      repeat ($urandom_range(0, 20)) @(negedge clk);
      settle();
      check(1'b0, edges_a / 50, "R3 random burst seconds");
    end

    // fast instance: walk the dial through its hard corners
    fast_to(9);    check(1'b1, edges_b, "R3 ones at 9");
    fast_to(10);   check(1'b1, edges_b, "R3 tens step");
    fast_to(59);   check(1'b1, edges_b, "R4 seconds at 59");
    fast_to(60);   check(1'b1, edges_b, "R4 minute advance");
    fast_to(3599); check(1'b1, edges_b, "R5 12:59:59");
    fast_to(3600); check(1'b1, edges_b, "R7 reload to 01:00:00");
    for (int k = 0; k < 6; k++) begin
      fast_to(edges_b + $urandom_range(100, 4000));
      check(1'b1, edges_b, "R5 random time of day");
    end
    fast_to(35999); check(1'b1, edges_b, "R6 09:59:59");
    fast_to(36000); check(1'b1, edges_b, "R6 tens bit sets 10:00:00");
    fast_to(39600); check(1'b1, edges_b, "R9 11:00:00");
    fast_to(43199); check(1'b1, edges_b, "R8 11:59:59");
    fast_to(43200); check(1'b1, edges_b, "R8 back to 12:00:00");
    fast_to(46799); check(1'b1, edges_b, "R7 second 12:59:59");
    fast_to(46800); check(1'b1, edges_b, "R7 second reload 01:00:00");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule